// File: doc/BRIEF.md
# Byte-Stream Pattern Trigger

This block watches a stream of bytes that have already been received and framed by a serial receiver. It raises a one-cycle trigger pulse whenever the most recent bytes equal a programmed pattern. The pattern holds up to eight bytes, and each byte has its own compare-enable bit. A programmable length selects how many of the pattern bytes take part in the match.

Because the length is programmable, a short pattern fires as soon as its last byte arrives. The trigger does not wait for further bytes to fill a fixed eight-byte window, so a short pattern followed by an idle line still fires. With the length set to eight, the block compares the full eight-byte window, and masked positions act as wildcards.

A clear input empties the byte history. Use it, for example, between captures, so that stale bytes cannot complete a match.

Top module: `byte_pattern_trigger`

## Requirements
- R1: After reset `matchPulse` is 0, and the history counts as empty.
- R2: When a byte is sampled with `byteValid` high at clock edge E and completes a match, `matchPulse` is high for the single cycle after edge E+1. Each pulse answers one accepted byte.
- R3: Pattern byte i occupies `patternBytes[8*i+7:8*i]`. With effective length N, pattern byte 0 must equal the oldest of the N most recent bytes, and pattern byte N-1 must equal the newest.
- R4: When `patternMask[i]` is 0, pattern byte i matches any received value. Only bytes at positions below N are compared.
- R5: A pattern shorter than eight bytes fires right after its last byte, with no further bytes needed. An idle line after that byte produces no extra pulse.
- R6: A `patternLen` value of 1 to 8 gives that length. A value of 0 or above 8 behaves as length 8, which compares the full eight-byte window.
- R7: No match is reported until at least N bytes have been accepted since reset or the last clear, even if the pattern would match the empty history.
- R8: `clearHist` empties the history. A byte presented in the same cycle as the clear is discarded. A match that was pending from the byte before the clear is cancelled.
- R9: Overlapping occurrences of the pattern each produce their own pulse. Bytes arriving on back-to-back cycles are each compared.
- R10: Idle cycles between bytes do not change the history or the match result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearHist | input | 1 | Empties the byte history |
| byteValid | input | 1 | A new byte is present on `byteData` |
| byteData | input | 8 | Received byte |
| patternBytes | input | 64 | Pattern; byte i in bits 8*i+7:8*i |
| patternMask | input | 8 | Per-byte compare enable (0 = wildcard) |
| patternLen | input | 4 | Match length, with 0 or above 8 meaning 8 |
| matchPulse | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situations to reach are the ones where the history and the pipeline interact. One is a clear that lands one cycle after the final byte of a match, which must cancel a pulse already in flight. Another is a run of overlapping pattern occurrences arriving with no gaps.

The stimulus reaches both directly. It streams bytes on consecutive cycles and places a clear in the cycle after the last byte. It then runs long random streams drawn from a three-symbol alphabet, with random lengths, masks, gaps and rare clears, so that partial and overlapping matches occur often.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Strobes handed from the control module to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;  // accept byteData into the history
    logic clearEn;  // empty history, drop anything in flight
    logic cmpEn;    // evaluate the compare on the current history
  } bptStrobes_t;

endpackage

// File: rtl/bpt_ctrl.sv
module bpt_ctrl
  import bpt_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             clearHist,
  input  logic [LEN_W-1:0] patternLen,
  output bptStrobes_t      strobes,
  output logic [LEN_W-1:0] effLen
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_BYTES);

  logic cmpPending;
  logic acceptByte;

  assign acceptByte = byteValid && !clearHist;

  // The compare runs exactly one cycle after a byte has entered the history.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpPending <= 1'b0;
    else       cmpPending <= acceptByte;
  end

  always_comb begin
    strobes.shiftEn = acceptByte;
    strobes.clearEn = clearHist;
    strobes.cmpEn   = cmpPending;
  end

  // Out-of-range lengths fall back to the full window.
  always_comb begin
    if (patternLen == '0 || patternLen > FULL_LEN) effLen = FULL_LEN;
    else                                           effLen = patternLen;
  end

  // R2: a compare is only ever requested for a byte accepted on the previous edge
  assert_cmp_after_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmpEn |-> $past(byteValid && !clearHist));

endmodule

// File: rtl/bpt_datapath.sv
module bpt_datapath
  import bpt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bptStrobes_t                 strobes,
  input  logic [DATA_W-1:0]           byteData,
  input  logic [MAX_BYTES*DATA_W-1:0] patternBytes,
  input  logic [MAX_BYTES-1:0]        patternMask,
  input  logic [LEN_W-1:0]            effLen,
  output logic                        matchPulse
);

  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_BYTES);

  // hist[0] is the newest byte.
  logic [DATA_W-1:0] hist [MAX_BYTES];
  logic [LEN_W-1:0]  fillCount;
  logic [MAX_BYTES-1:0] posOk;
  logic enoughBytes;
  logic hit;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : gHist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                hist[g] <= '0;
      else if (strobes.clearEn) hist[g] <= '0;
      else if (strobes.shiftEn) begin
        if (g == 0) hist[g] <= byteData;
        else        hist[g] <= hist[(g == 0) ? 0 : g - 1];
      end
    end
  end

  // Number of valid bytes held, saturating at the window size.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                fillCount <= '0;
    else if (strobes.clearEn) fillCount <= '0;
    else if (strobes.shiftEn && fillCount < FULL_LEN)
      fillCount <= fillCount + LEN_W'(1);
  end

  // Pattern byte i is compared against the byte received (effLen-1-i) bytes ago.
  for (genvar i = 0; i < MAX_BYTES; i++) begin : gCmp
    logic             inUse;
    logic [LEN_W-1:0] srcIdx;
    logic [DATA_W-1:0] want;
    assign inUse    = LEN_W'(i) < effLen;
    assign srcIdx   = effLen - LEN_W'(i) - LEN_W'(1);
    assign want     = patternBytes[i*DATA_W +: DATA_W];
    assign posOk[i] = !inUse || !patternMask[i] ||
                      (hist[srcIdx[IDX_W-1:0]] == want);
  end

  assign enoughBytes = fillCount >= effLen;
  assign hit         = (&posOk) && enoughBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                matchPulse <= 1'b0;
    else if (strobes.clearEn) matchPulse <= 1'b0;
    else                      matchPulse <= strobes.cmpEn && hit;
  end

  // R3: an accepted byte becomes the newest history entry
  assert_newest_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftEn && !strobes.clearEn) |=> (hist[0] == $past(byteData)));

  // R8: a clear leaves an empty history and no pulse
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearEn |=> (fillCount == '0 && !matchPulse));

  // R9: each pulse answers a compare request that was not cancelled
  assert_pulse_needs_cmp_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(strobes.cmpEn && !strobes.clearEn));

  // R7: a pulse needs at least effLen accepted bytes
  assert_enough_bytes_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(fillCount) >= $past(effLen)));

  // R7: the fill count never passes the window size
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_LEN);

endmodule

// File: rtl/byte_pattern_trigger.sv
module byte_pattern_trigger
  import bpt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clearHist,
  input  logic                        byteValid,
  input  logic [DATA_W-1:0]           byteData,
  input  logic [MAX_BYTES*DATA_W-1:0] patternBytes,
  input  logic [MAX_BYTES-1:0]        patternMask,
  input  logic [LEN_W-1:0]            patternLen,
  output logic                        matchPulse
);

  bptStrobes_t      strobes;
  logic [LEN_W-1:0] effLen;

  bpt_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .clearHist (clearHist),
    .patternLen(patternLen),
    .strobes   (strobes),
    .effLen    (effLen)
  );

  bpt_datapath #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .byteData    (byteData),
    .patternBytes(patternBytes),
    .patternMask (patternMask),
    .effLen      (effLen),
    .matchPulse  (matchPulse)
  );

endmodule

// File: tb/byte_pattern_trigger_test.sv
`timescale 1ns/1ps
module byte_pattern_trigger_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearHist = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [63:0] patternBytes = '0;
  logic [7:0]  patternMask = '1;
  logic [3:0]  patternLen = 4'd8;
  logic        matchPulse;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [7:0] mHist [8];
  int mFill = 0;
  logic expQ [2];

  always #2.5 clk = ~clk;

  byte_pattern_trigger uut (
    .clk(clk), .rstN(rstN), .clearHist(clearHist), .byteValid(byteValid),
    .byteData(byteData), .patternBytes(patternBytes), .patternMask(patternMask),
    .patternLen(patternLen), .matchPulse(matchPulse)
  );

  function automatic int effLenOf(logic [3:0] l);
    return (l == 0 || l > 8) ? 8 : int'(l);
  endfunction

  function automatic logic modelHit();
    int n = effLenOf(patternLen);
    if (mFill < n) return 1'b0;
    for (int i = 0; i < n; i++)
      if (patternMask[i] && patternBytes[i*8 +: 8] != mHist[n-1-i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 8; i++) mHist[i] = '0;
    mFill = 0;
  endtask

  task automatic modelPush(logic [7:0] b);
    for (int i = 7; i > 0; i--) mHist[i] = mHist[i-1];
    mHist[0] = b;
    if (mFill < 8) mFill++;
  endtask

  task automatic checkInt(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: check the output due now, then drive the next inputs.
  task automatic step(bit v, logic [7:0] b, bit clr);
    @(negedge clk);
    checkInt({curReq, " matchPulse"}, int'(matchPulse), int'(expQ[1]));
    if (matchPulse) pulseCnt++;
    expQ[1] = expQ[0];
    byteValid = v; byteData = b; clearHist = clr;
    if (clr) begin
      modelClear(); expQ[0] = 1'b0; expQ[1] = 1'b0;
    end else if (v) begin
      modelPush(b); expQ[0] = modelHit();
    end else expQ[0] = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 8'h00, 0);
  endtask

  task automatic setCfg(logic [63:0] p, logic [7:0] m, logic [3:0] l);
    idle(2);
    patternBytes = p; patternMask = m; patternLen = l;
  endtask

  task automatic sendStr(string s);
    for (int k = 0; k < s.len(); k++) step(1, s[k], 0);
  endtask

  function automatic logic [63:0] packStr(string s);
    logic [63:0] r = '0;
    for (int k = 0; k < s.len() && k < 8; k++) r[k*8 +: 8] = s[k];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    expQ[0] = 1'b0; expQ[1] = 1'b0;
    modelClear();
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: output low in reset and right after release
    checkInt("R1 in reset", int'(matchPulse), 0);
    rstN = 1'b1;
    curReq = "R1";
    idle(3);

    // R7 / R6: all-zero pattern, full window, needs eight bytes
    curReq = "R7";
    setCfg('0, 8'hFF, 4'd8);
    pulseCnt = 0;
    for (int k = 0; k < 7; k++) step(1, 8'h00, 0);
    idle(3);
    checkInt("R7 no pulse before full", pulseCnt, 0);
    step(1, 8'h00, 0); idle(3);
    checkInt("R6 full window pulse", pulseCnt, 1);

    // R5 / R2: short pattern then silence
    curReq = "R5";
    step(0, 0, 1);
    setCfg(packStr("p00"), 8'hFF, 4'd3);
    pulseCnt = 0;
    sendStr("xp00"); idle(6);
    checkInt("R5 short pattern fired once", pulseCnt, 1);

    // R3: reversed order must not match
    curReq = "R3";
    pulseCnt = 0;
    sendStr("00p"); idle(3);
    checkInt("R3 reversed order", pulseCnt, 0);

    // R4: middle byte masked out
    curReq = "R4";
    setCfg(packStr("pQ0"), 8'b0000_0101, 4'd3);
    pulseCnt = 0;
    sendStr("pZ0"); idle(3);
    checkInt("R4 wildcard position", pulseCnt, 1);

    // R9: overlapping occurrences back to back
    curReq = "R9";
    setCfg(packStr("AA"), 8'hFF, 4'd2);
    pulseCnt = 0;
    sendStr("AAAA"); idle(3);
    checkInt("R9 overlap pulses", pulseCnt, 3);

    // R10: gaps between bytes
    curReq = "R10";
    pulseCnt = 0;
    step(1, "B", 0); idle(4); step(1, "A", 0); idle(5); step(1, "A", 0); idle(3);
    checkInt("R10 gapped bytes", pulseCnt, 1);

    // R6: length 0 and 12 behave as 8
    curReq = "R6";
    setCfg(packStr("abcdefgh"), 8'hFF, 4'd0);
    pulseCnt = 0;
    sendStr("abcdefgh"); idle(3);
    checkInt("R6 length 0 as 8", pulseCnt, 1);
    setCfg(packStr("abcdefgh"), 8'hFF, 4'd12);
    pulseCnt = 0;
    sendStr("bcdefgh"); idle(3);
    sendStr("abcdefgh"); idle(3);
    checkInt("R6 length 12 as 8", pulseCnt, 1);

    // R8: clear between bytes, clear with a byte, clear after the last byte
    curReq = "R8";
    setCfg(packStr("AB"), 8'hFF, 4'd2);
    pulseCnt = 0;
    step(1, "A", 0); step(0, 0, 1); step(1, "B", 0); idle(3);
    step(1, "A", 0); step(1, "B", 1); step(1, "B", 0); idle(3);
    step(1, "A", 0); step(1, "B", 0); step(0, 0, 1); idle(3);
    checkInt("R8 clear cases", pulseCnt, 0);

    // R2 / R10: constrained random
    curReq = "R2 random";
    for (int blk = 0; blk < 60; blk++) begin
      logic [63:0] p;
      logic [7:0]  m;
      for (int k = 0; k < 8; k++) p[k*8 +: 8] = 8'($urandom_range(0, 2));
      m = 8'($urandom) | 8'($urandom);
      setCfg(p, m, 4'($urandom_range(0, 10)));
      for (int c = 0; c < 60; c++) begin
        int r = int'($urandom_range(0, 99));
        if (r < 2)       step(0, 0, 1);
        else if (r < 70) step(1, 8'($urandom_range(0, 2)), 0);
        else             step(0, 8'($urandom), 0);
      end
    end
    idle(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule